// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

The watchdog runs off a slow time base. It does not count system clocks. It counts pulses on a low-speed tick enable, and each pulse is one cycle long. Software controls it through four small registers behind one write port and one read port. All control actions go through a single key register, and each action is a 16-bit magic value written there:

- One value opens the two configuration registers for writing.
- One value starts the countdown.
- One value refreshes the countdown.
- Any other value closes the configuration registers again.

Once the countdown starts, software has no way to stop it.

The count rate comes from a divide code, which selects a divide of 4 up to 256 in powers of two. The start value comes from a 12-bit reload register. Each configuration write must reach the counting side before it takes effect. That transfer is modelled as a fixed latency of tick pulses, and a busy bit in the status register is set while the transfer is pending. When the down-counter runs out, the block raises a one-cycle reset request. It then starts the next period from the reload value.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the divide code (select 1) reads 0, the reload value (select 2) reads 0xFFF, the status (select 3) reads 0, and `rst_req` is low.
- R2: A write to select 1 or select 2 changes nothing unless the last key written to select 0 was 0x5555.
- R3: Writing any key other than 0x5555 to select 0 closes write access. This covers 0xAAAA, 0xCCCC and all other values.
- R4: An accepted divide-code write sets status bit 0, and an accepted reload write sets status bit 1. Each bit stays set for 5 tick pulses and clears on the fifth.
- R5: A write to a configuration register is ignored while that register's status bit is set.
- R6: Writing 0xCCCC starts the countdown. With reload R and code c, `rst_req` pulses high for exactly one clock cycle on the (R+1)·2^(c+2)-th tick after the start.
- R7: After a reset request, the countdown restarts on its own and fires again after the same number of ticks.
- R8: Writing 0xAAAA restarts the full period from the reload value.
- R9: Once started, the watchdog keeps running. No key value stops it, and only a system reset does.
- R10: A divide code above 6 is stored as 6, which selects a divide of 256.
- R11: Before it is started, the block never raises `rst_req`, however many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Low-speed time-base enable, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 key, 1 divide code, 2 reload |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read select: 1 divide code, 2 reload, 3 status (bit 0 code busy, bit 1 reload busy) |
| rd_data | output | 16 | Read data, combinational from `rd_sel` |
| rst_req | output | 1 | One-cycle reset request when the countdown expires |

## Verification
A wrong lock or busy state appears at the read port right away. A write that should have been refused shows up as a changed readback in the next cycle, and a wrong latency moves the clearing of a status bit by whole ticks. A wrong count, a wrong divide or a missed reload does not show at once. It only appears when the reset request arrives, as a pulse on the wrong tick, which can be as far as one full period away. For that reason every expiry is measured as an exact tick count from the start or the refresh.

// File: rtl/kwdg_pkg.sv
package kwdg_pkg;
  localparam int KEY_W = 16;
  localparam int PRE_W = 3;
  localparam int PSC_W = 8;
  localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
  localparam logic [PRE_W-1:0] PRE_MAX     = 3'd6;

  typedef enum logic [1:0] {
    SEL_KEY  = 2'd0,
    SEL_PRE  = 2'd1,
    SEL_RLD  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  // Out-of-range codes saturate at the slowest divide.
  function automatic logic [PRE_W-1:0] clamp_code(input logic [PRE_W-1:0] c);
    return (c > PRE_MAX) ? PRE_MAX : c;
  endfunction

  // Number of ticks per counter step: 4 shifted left by the code.
  function automatic logic [PSC_W:0] div_ratio(input logic [PRE_W-1:0] c);
    logic [PSC_W:0] base;
    base = (PSC_W+1)'(4);
    return base << clamp_code(c);
  endfunction
endpackage

// File: rtl/kwdg_cfg_slot.sv
module kwdg_cfg_slot #(
  parameter int W       = 12,
  parameter int LAT     = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_ok,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         busy,
  output logic         accept
);
  localparam int LW = $clog2(LAT + 1);
  localparam logic [LW-1:0] LAT_V = LW'(LAT);

  logic [LW-1:0] lat_cnt;

  assign busy   = (lat_cnt != '0);
  assign accept = wr_ok && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow  <= RST_VAL;
      active  <= RST_VAL;
      lat_cnt <= '0;
    end else if (accept) begin
      shadow  <= wr_val;
      lat_cnt <= LAT_V;
    end else if (tick && busy) begin
      lat_cnt <= lat_cnt - 1'b1;
      if (lat_cnt == LW'(1)) active <= shadow;
    end
  end
endmodule

// File: rtl/kwdg_countdown.sv
module kwdg_countdown
  import kwdg_pkg::*;
#(
  parameter int RLD_W = 12,
  parameter logic [RLD_W-1:0] RLD_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             refresh,
  input  logic [PRE_W-1:0] pre_code,
  input  logic [RLD_W-1:0] rld_val,
  output logic             running,
  output logic             step,
  output logic             expire,
  output logic             rst_req
);
  logic [PSC_W-1:0] psc;
  logic [RLD_W-1:0] cnt;
  logic [PSC_W:0]   div_m1;

  assign div_m1 = div_ratio(pre_code) - 1'b1;
  assign step   = running && tick && ({1'b0, psc} >= div_m1);
  assign expire = step && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      psc     <= '0;
      cnt     <= RLD_RST;
      rst_req <= 1'b0;
    end else begin
      rst_req <= expire;
      if (start) running <= 1'b1;
      if (start || refresh) begin
        psc <= '0;
        cnt <= rld_val;
      end else if (running && tick) begin
        if (step) begin
          psc <= '0;
          cnt <= (cnt == '0) ? rld_val : cnt - 1'b1;
        end else begin
          psc <= psc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwdg_pkg::*;
#(
  parameter int RLD_W = 12,
  parameter int LAT   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [KEY_W-1:0]  wr_data,
  input  logic [1:0]        rd_sel,
  output logic [KEY_W-1:0]  rd_data,
  output logic              rst_req
);
  localparam logic [RLD_W-1:0] RLD_RST = '1;

  logic key_wr, ev_unlock, ev_refresh, ev_start;
  logic unlocked;
  logic pre_wr_ok, rld_wr_ok, pre_accept, rld_accept;
  logic pre_busy, rld_busy;
  logic [PRE_W-1:0] pre_shadow, pre_active;
  logic [RLD_W-1:0] rld_shadow, rld_active;
  logic running, step, expire;

  // Key decode
  assign key_wr     = wr_en && (wr_sel == SEL_KEY);
  assign ev_unlock  = key_wr && (wr_data == KEY_UNLOCK);
  assign ev_refresh = key_wr && (wr_data == KEY_REFRESH);
  assign ev_start   = key_wr && (wr_data == KEY_START);

  always_ff @(posedge clk) begin
    if (!rst_n)      unlocked <= 1'b0;
    else if (key_wr) unlocked <= ev_unlock;
  end

  assign pre_wr_ok = wr_en && (wr_sel == SEL_PRE) && unlocked;
  assign rld_wr_ok = wr_en && (wr_sel == SEL_RLD) && unlocked;

  kwdg_cfg_slot #(.W(PRE_W), .LAT(LAT), .RST_VAL('0)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick_in), .wr_ok(pre_wr_ok),
    .wr_val(clamp_code(wr_data[PRE_W-1:0])),
    .shadow(pre_shadow), .active(pre_active), .busy(pre_busy), .accept(pre_accept)
  );

  kwdg_cfg_slot #(.W(RLD_W), .LAT(LAT), .RST_VAL(RLD_RST)) u_rld (
    .clk(clk), .rst_n(rst_n), .tick(tick_in), .wr_ok(rld_wr_ok),
    .wr_val(wr_data[RLD_W-1:0]),
    .shadow(rld_shadow), .active(rld_active), .busy(rld_busy), .accept(rld_accept)
  );

  kwdg_countdown #(.RLD_W(RLD_W), .RLD_RST(RLD_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_in), .start(ev_start), .refresh(ev_refresh),
    .pre_code(pre_active), .rld_val(rld_active),
    .running(running), .step(step), .expire(expire), .rst_req(rst_req)
  );

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_PRE:  rd_data[PRE_W-1:0] = pre_shadow;
      SEL_RLD:  rd_data[RLD_W-1:0] = rld_shadow;
      SEL_STAT: rd_data[1:0]       = {rld_busy, pre_busy};
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/kwdg_checker.sv
module kwdg_checker
  import kwdg_pkg::*;
#(
  parameter int RLD_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [KEY_W-1:0] wr_data,
  input logic             unlocked,
  input logic             running,
  input logic             rst_req,
  input logic             pre_busy,
  input logic             rld_busy,
  input logic [PRE_W-1:0] pre_shadow,
  input logic [RLD_W-1:0] rld_shadow
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R6
  AST_NO_FIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> running); // R11
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running); // R9
  AST_LOCKED_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_PRE && !unlocked) |=> $stable(pre_shadow)); // R2
  AST_LOCKED_RLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_RLD && !unlocked) |=> $stable(rld_shadow)); // R2
  AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_KEY && wr_data != KEY_UNLOCK) |=> !unlocked); // R3
  AST_BUSY_GUARD_RLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_RLD && rld_busy) |=> $stable(rld_shadow)); // R5
  AST_BUSY_GUARD_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_PRE && pre_busy) |=> $stable(pre_shadow)); // R5
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_shadow <= PRE_MAX); // R10
endmodule

bind keyed_watchdog kwdg_checker #(.RLD_W(RLD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .unlocked(unlocked), .running(running), .rst_req(rst_req),
  .pre_busy(pre_busy), .rld_busy(rld_busy),
  .pre_shadow(pre_shadow), .rld_shadow(rld_shadow)
);

// File: tb/test_keyed_watchdog.sv
`timescale 1ns/1ps
module test_keyed_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        rst_req;
  int tests = 0;
  int fails = 0;
  logic fired;

  always #2 clk = ~clk;

  keyed_watchdog i_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .rst_req(rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk) begin wr_en = 1'b1; wr_sel = sel; wr_data = data; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output int val);
    @(negedge clk) rd_sel = sel;
    #1 val = int'(rd_data);
  endtask

  task automatic tick();
    @(negedge clk) tick_in = 1'b1;
    @(negedge clk) tick_in = 1'b0;
    fired = rst_req;
  endtask

  task automatic ticks(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin tick(); if (fired) seen++; end
  endtask

  task automatic ticks_to_fire(input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      tick();
      if (fired) begin n = i; break; end
    end
  endtask

  // Unlock, write code and reload, let both transfers finish.
  task automatic configure(input logic [2:0] code, input logic [11:0] rld);
    int s;
    wr(2'd0, 16'h5555);
    wr(2'd1, {13'd0, code});
    wr(2'd2, {4'd0, rld});
    ticks(5, s);
  endtask

  task automatic t_reset_state();
    int v;
    do_reset();
    rd(2'd1, v); check("R1 code", v, 0);
    rd(2'd2, v); check("R1 reload", v, 12'hFFF);
    rd(2'd3, v); check("R1 status", v, 0);
    check("R1 rst_req", int'(rst_req), 0);
  endtask

  task automatic t_lock();
    int v;
    do_reset();
    wr(2'd1, 16'd3); wr(2'd2, 16'd100);
    rd(2'd1, v); check("R2 locked code", v, 0);
    rd(2'd2, v); check("R2 locked reload", v, 12'hFFF);
    rd(2'd3, v); check("R2 no busy", v, 0);
    wr(2'd0, 16'h5555); wr(2'd0, 16'h1234); wr(2'd2, 16'd7);
    rd(2'd2, v); check("R3 other key relocks", v, 12'hFFF);
    wr(2'd0, 16'h5555); wr(2'd0, 16'hAAAA); wr(2'd2, 16'd7);
    rd(2'd2, v); check("R3 refresh key relocks", v, 12'hFFF);
    wr(2'd0, 16'h5555); wr(2'd0, 16'hCCCC); wr(2'd2, 16'd7);
    rd(2'd2, v); check("R3 start key relocks", v, 12'hFFF);
  endtask

  task automatic t_busy();
    int v, s;
    do_reset();
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'd2);
    rd(2'd3, v); check("R4 code busy set", v, 1);
    wr(2'd2, 16'd9);
    rd(2'd3, v); check("R4 both busy", v, 3);
    wr(2'd2, 16'd20);
    rd(2'd2, v); check("R5 write while busy ignored", v, 9);
    ticks(4, s);
    rd(2'd3, v); check("R4 busy after 4 ticks", v, 3);
    tick();
    rd(2'd3, v); check("R4 busy cleared on 5th", v, 0);
    wr(2'd1, 16'd7);
    rd(2'd1, v); check("R10 code 7 clamps", v, 6);
    check("R11 no fire when stopped", s + int'(fired), 0);
    ticks(5, s);
  endtask

  task automatic t_countdown();
    int n, s;
    do_reset();
    configure(3'd0, 12'd2);
    ticks(40, s);
    check("R11 no fire before start", s, 0);
    wr(2'd0, 16'hCCCC);
    ticks_to_fire(100, n); check("R6 first expiry tick", n, 12);
    @(negedge clk); check("R6 pulse one cycle", int'(rst_req), 0);
    ticks_to_fire(100, n); check("R7 repeat expiry", n, 12);
    ticks(8, s);
    wr(2'd0, 16'hAAAA);
    ticks_to_fire(100, n); check("R8 refresh restarts period", n + s, 12);
    wr(2'd0, 16'h1234);
    ticks_to_fire(100, n); check("R9 other key does not stop", n, 12);
  endtask

  task automatic t_divide();
    int n;
    do_reset();
    configure(3'd2, 12'd1);
    wr(2'd0, 16'hCCCC);
    ticks_to_fire(200, n); check("R6 divide 16 reload 1", n, 32);
    do_reset();
    configure(3'd7, 12'd0);
    wr(2'd0, 16'hCCCC);
    ticks_to_fire(600, n); check("R10 clamped divide 256", n, 256);
    do_reset();
    wr(2'd0, 16'hCCCC);
    ticks_to_fire(20000, n); check("R6 default period", n, 16384);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_lock();
    t_busy();
    t_countdown();
    t_divide();
    finish_run();
  end
endmodule